// File: doc/BRIEF.md
# Configuration-access PIO engine

This block lets software perform one 32-bit PCIe configuration read or write through a small memory-mapped register port. Software first programs three things: a transaction type, a 64-bit target address split into a low and a high word, and the write data with its byte strobes. It then sets the launch bit. The engine issues exactly one request on a valid/ready downstream port and waits for a single completion beat.

When the completion arrives, the engine stores the returned data and the 3-bit completion status. It then clears the launch bit and sets a sticky done flag. Software clears that flag by writing 1 to it, and a mask bit gates it onto an interrupt line. A completer that never answers is cut off after a parameterised number of cycles.

Software normally polls either the launch bit or the done flag. While a request is outstanding, the request-description registers are locked, so the request on the downstream port cannot change under the completer.

Top module: `cfg_pio_engine`

## Requirements
- R1: After reset every register reads 0, `irq_o` is 0 and `req_valid_o` is 0.
- R2: Register map (byte offsets): 0x00 control, 0x04 status, 0x08 address low, 0x0C address high, 0x10 write data, 0x14 strobe, 0x18 read data, 0x1C launch, 0x20 done flag, 0x24 interrupt mask.
  - Control keeps only bits 3:0 (type) and bit 24 (window-disable flag); all other control bits read 0.
  - Strobe keeps only bits 3:0. The address and write-data registers keep all 32 bits.
  - Writes to the status and read-data offsets have no effect, and offsets not in the map read 0.
- R3: A write with bit 0 = 1 to the launch offset while idle, with type 0x8 (Type0 read), 0x9 (Type1 read), 0xA (Type0 write) or 0xB (Type1 write), raises `req_valid_o` on the next cycle.
  - The request carries `req_write_o` = type bit 1, `req_type1_o` = type bit 0, `req_addr_o` = {high, low}, the write data and the strobe.
  - All of these are held until `req_ready_i`. The low address word carries the bus number in bits 27:20, the device in bits 19:15, the function in bits 14:12 and the register offset below them.
- R4: A completion accepted after the request handshake does four things: for a read it stores `cpl_data_i` as read data; it stores `cpl_status_i` in status bits 9:7; it makes launch bit 0 read 0; and it sets done-flag bit 0.
- R5: A completed write transaction leaves the read-data register unchanged.
- R6: Writing 1 to done-flag bit 0 clears it and writing 0 does nothing. A completion in the same cycle as a clearing write leaves the flag set.
- R7: `irq_o` is 1 exactly when done-flag bit 0 is 1 and interrupt-mask bit 0 is 0.
- R8: While a request is outstanding, writes to control, both address words, write data, strobe and launch are ignored.
- R9: If no completion is accepted within TIMEOUT_CYCLES cycles of the launch, the request ends at that edge. The end of the request withdraws `req_valid_o`, sets read data to 0xFFFFFFFF and status to 3'b111, clears the launch bit and sets the done flag.
- R10: A launch with a type outside 0x8 to 0xB issues no request. It ends one cycle later with read data 0xFFFFFFFF, status 3'b001 and the done flag set.
- R11: One launch produces exactly one request handshake, and `cpl_valid_i` is ignored while no accepted request is waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational on reg_addr_i) |
| irq_o | output | 1 | Masked done interrupt |
| req_valid_o | output | 1 | Request valid |
| req_ready_i | input | 1 | Request accepted by completer |
| req_write_o | output | 1 | 1 = configuration write |
| req_type1_o | output | 1 | 1 = Type1 access |
| req_addr_o | output | 64 | Target address {high, low} |
| req_data_o | output | 32 | Write data |
| req_strb_o | output | 4 | Byte strobes |
| cpl_valid_i | input | 1 | Completion beat |
| cpl_data_i | input | 32 | Completion read data |
| cpl_status_i | input | 3 | Completion status code |

## Verification
The done flag has two writers: the request sequencer sets it, and software clears it by writing 1. Both can land on the same clock edge. The bench provokes this by holding its completer in an accept-but-stay-silent mode and then raising `cpl_valid_i` in the very cycle that a write of 1 reaches the done-flag offset. The design is judged correct if the flag reads 1 afterwards, because the completion must not be lost. A second overlap is a register write arriving while a request is outstanding; after the request, read-back must show the pre-launch values.

// File: rtl/cfg_pio_pkg.sv
package cfg_pio_pkg;
  localparam int unsigned REG_W       = 32;
  localparam int unsigned STRB_W      = 4;
  localparam int unsigned TYPE_W      = 4;
  localparam int unsigned STS_W       = 3;
  localparam int unsigned WIN_DIS_BIT = 24;
  localparam int unsigned STS_LSB     = 7;

  localparam logic [7:0] OFF_CTRL    = 8'h00;
  localparam logic [7:0] OFF_STAT    = 8'h04;
  localparam logic [7:0] OFF_ADDR_LO = 8'h08;
  localparam logic [7:0] OFF_ADDR_HI = 8'h0C;
  localparam logic [7:0] OFF_WDATA   = 8'h10;
  localparam logic [7:0] OFF_STRB    = 8'h14;
  localparam logic [7:0] OFF_RDATA   = 8'h18;
  localparam logic [7:0] OFF_START   = 8'h1C;
  localparam logic [7:0] OFF_ISR     = 8'h20;
  localparam logic [7:0] OFF_IMASK   = 8'h24;

  typedef enum logic [TYPE_W-1:0] {
    TY_RD_T0 = 4'h8,
    TY_RD_T1 = 4'h9,
    TY_WR_T0 = 4'hA,
    TY_WR_T1 = 4'hB
  } cfg_type_e;

  localparam logic [STS_W-1:0] STS_BAD_TYPE = 3'b001;
  localparam logic [STS_W-1:0] STS_TIMEOUT  = 3'b111;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_BAD
  } pio_state_e;
endpackage

// File: rtl/cfg_pio_regs.sv
module cfg_pio_regs
  import cfg_pio_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                reg_wr_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic [REG_W-1:0]    reg_wdata_i,
  output logic [REG_W-1:0]    reg_rdata_o,
  input  logic                busy_i,
  input  logic                done_i,
  input  logic                done_rdata_we_i,
  input  logic [REG_W-1:0]    done_rdata_i,
  input  logic [STS_W-1:0]    done_sts_i,
  output logic                launch_o,
  output logic [TYPE_W-1:0]   type_o,
  output logic [2*REG_W-1:0]  addr_o,
  output logic [REG_W-1:0]    wdata_o,
  output logic [STRB_W-1:0]   strb_o,
  output logic                irq_o
);
  localparam logic [ADDR_W-1:0] A_CTRL    = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_STAT    = ADDR_W'(OFF_STAT);
  localparam logic [ADDR_W-1:0] A_ADDR_LO = ADDR_W'(OFF_ADDR_LO);
  localparam logic [ADDR_W-1:0] A_ADDR_HI = ADDR_W'(OFF_ADDR_HI);
  localparam logic [ADDR_W-1:0] A_WDATA   = ADDR_W'(OFF_WDATA);
  localparam logic [ADDR_W-1:0] A_STRB    = ADDR_W'(OFF_STRB);
  localparam logic [ADDR_W-1:0] A_RDATA   = ADDR_W'(OFF_RDATA);
  localparam logic [ADDR_W-1:0] A_START   = ADDR_W'(OFF_START);
  localparam logic [ADDR_W-1:0] A_ISR     = ADDR_W'(OFF_ISR);
  localparam logic [ADDR_W-1:0] A_IMASK   = ADDR_W'(OFF_IMASK);

  logic [TYPE_W-1:0] type_q;
  logic              win_dis_q;
  logic [REG_W-1:0]  addr_lo_q, addr_hi_q, wdata_q, rdata_q;
  logic [STRB_W-1:0] strb_q;
  logic [STS_W-1:0]  sts_q;
  logic              isr_q, mask_q;
  logic              wr_open;

  // request description is frozen while a request is outstanding
  assign wr_open  = reg_wr_i && !busy_i;
  assign launch_o = wr_open && (reg_addr_i == A_START) && reg_wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      type_q    <= '0;
      win_dis_q <= 1'b0;
      addr_lo_q <= '0;
      addr_hi_q <= '0;
      wdata_q   <= '0;
      strb_q    <= '0;
    end else if (wr_open) begin
      if (reg_addr_i == A_CTRL) begin
        type_q    <= reg_wdata_i[TYPE_W-1:0];
        win_dis_q <= reg_wdata_i[WIN_DIS_BIT];
      end
      if (reg_addr_i == A_ADDR_LO) addr_lo_q <= reg_wdata_i;
      if (reg_addr_i == A_ADDR_HI) addr_hi_q <= reg_wdata_i;
      if (reg_addr_i == A_WDATA)   wdata_q   <= reg_wdata_i;
      if (reg_addr_i == A_STRB)    strb_q    <= reg_wdata_i[STRB_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      sts_q   <= '0;
    end else if (done_i) begin
      sts_q <= done_sts_i;
      if (done_rdata_we_i) rdata_q <= done_rdata_i;
    end
  end

  // set by completion has priority over software clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                                  isr_q <= 1'b0;
    else if (done_i)                                              isr_q <= 1'b1;
    else if (reg_wr_i && reg_addr_i == A_ISR && reg_wdata_i[0])   isr_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   mask_q <= 1'b0;
    else if (reg_wr_i && reg_addr_i == A_IMASK)    mask_q <= reg_wdata_i[0];
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_CTRL: begin
        reg_rdata_o[TYPE_W-1:0]  = type_q;
        reg_rdata_o[WIN_DIS_BIT] = win_dis_q;
      end
      A_STAT:    reg_rdata_o[STS_LSB +: STS_W] = sts_q;
      A_ADDR_LO: reg_rdata_o = addr_lo_q;
      A_ADDR_HI: reg_rdata_o = addr_hi_q;
      A_WDATA:   reg_rdata_o = wdata_q;
      A_STRB:    reg_rdata_o[STRB_W-1:0] = strb_q;
      A_RDATA:   reg_rdata_o = rdata_q;
      A_START:   reg_rdata_o[0] = busy_i;
      A_ISR:     reg_rdata_o[0] = isr_q;
      A_IMASK:   reg_rdata_o[0] = mask_q;
      default:   ;
    endcase
  end

  assign type_o  = type_q;
  assign addr_o  = {addr_hi_q, addr_lo_q};
  assign wdata_o = wdata_q;
  assign strb_o  = strb_q;
  assign irq_o   = isr_q && !mask_q;

  p_done_sets_flag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> isr_q);
  p_lock_addr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && reg_wr_i && reg_addr_i == A_ADDR_LO) |=> $stable(addr_lo_q));
  p_lock_strb_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && reg_wr_i && reg_addr_i == A_STRB) |=> $stable(strb_q));
  p_no_done_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> busy_i);
endmodule

// File: rtl/cfg_pio_fsm.sv
module cfg_pio_fsm
  import cfg_pio_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYCLES = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              launch_i,
  input  logic [TYPE_W-1:0] type_i,
  input  logic              req_ready_i,
  input  logic              cpl_valid_i,
  input  logic [REG_W-1:0]  cpl_data_i,
  input  logic [STS_W-1:0]  cpl_status_i,
  output logic              req_valid_o,
  output logic              req_write_o,
  output logic              req_type1_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              done_rdata_we_o,
  output logic [REG_W-1:0]  done_rdata_o,
  output logic [STS_W-1:0]  done_sts_o
);
  localparam int unsigned       CNT_W    = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(TIMEOUT_CYCLES - 1);

  pio_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q;
  logic             type_ok, in_flight, cpl_hit, tmo_hit;

  assign type_ok   = (type_i[TYPE_W-1:TYPE_W-2] == 2'b10);
  assign in_flight = (state_q == ST_REQ) || (state_q == ST_WAIT);
  assign cpl_hit   = (state_q == ST_WAIT) && cpl_valid_i;
  assign tmo_hit   = in_flight && !cpl_hit && (cnt_q == CNT_LAST);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (launch_i) state_d = type_ok ? ST_REQ : ST_BAD;
      ST_REQ: begin
        if (tmo_hit)          state_d = ST_IDLE;
        else if (req_ready_i) state_d = ST_WAIT;
      end
      ST_WAIT: if (cpl_hit || tmo_hit) state_d = ST_IDLE;
      ST_BAD:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  // cycles elapsed since launch; zero whenever nothing is outstanding
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!in_flight)  cnt_q <= '0;
    else if (!tmo_hit)    cnt_q <= cnt_q + 1'b1;
  end

  assign busy_o          = (state_q != ST_IDLE);
  assign req_valid_o     = (state_q == ST_REQ);
  assign req_write_o     = type_i[1];
  assign req_type1_o     = type_i[0];
  assign done_o          = cpl_hit || tmo_hit || (state_q == ST_BAD);
  assign done_rdata_we_o = cpl_hit ? !type_i[1] : 1'b1;
  assign done_rdata_o    = cpl_hit ? cpl_data_i : '1;
  assign done_sts_o      = cpl_hit ? cpl_status_i :
                           ((state_q == ST_BAD) ? STS_BAD_TYPE : STS_TIMEOUT);

  p_req_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && !req_ready_i && !done_o) |=> req_valid_o);
  p_single_req_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && req_ready_i) |=> !req_valid_o);
  p_bad_no_req_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (launch_i && !busy_o && !type_ok) |=> (!req_valid_o && done_o));
  p_done_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
endmodule

// File: rtl/cfg_pio_engine.sv
module cfg_pio_engine
  import cfg_pio_pkg::*;
#(
  parameter int unsigned ADDR_W         = 8,
  parameter int unsigned TIMEOUT_CYCLES = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              irq_o,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic              req_write_o,
  output logic              req_type1_o,
  output logic [63:0]       req_addr_o,
  output logic [31:0]       req_data_o,
  output logic [3:0]        req_strb_o,
  input  logic              cpl_valid_i,
  input  logic [31:0]       cpl_data_i,
  input  logic [2:0]        cpl_status_i
);
  logic              launch, busy, done, done_we;
  logic [REG_W-1:0]  done_rdata;
  logic [STS_W-1:0]  done_sts;
  logic [TYPE_W-1:0] type_w;

  cfg_pio_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .reg_wr_i        (reg_wr_i),
    .reg_addr_i      (reg_addr_i),
    .reg_wdata_i     (reg_wdata_i),
    .reg_rdata_o     (reg_rdata_o),
    .busy_i          (busy),
    .done_i          (done),
    .done_rdata_we_i (done_we),
    .done_rdata_i    (done_rdata),
    .done_sts_i      (done_sts),
    .launch_o        (launch),
    .type_o          (type_w),
    .addr_o          (req_addr_o),
    .wdata_o         (req_data_o),
    .strb_o          (req_strb_o),
    .irq_o           (irq_o)
  );

  cfg_pio_fsm #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_fsm (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .launch_i        (launch),
    .type_i          (type_w),
    .req_ready_i     (req_ready_i),
    .cpl_valid_i     (cpl_valid_i),
    .cpl_data_i      (cpl_data_i),
    .cpl_status_i    (cpl_status_i),
    .req_valid_o     (req_valid_o),
    .req_write_o     (req_write_o),
    .req_type1_o     (req_type1_o),
    .busy_o          (busy),
    .done_o          (done),
    .done_rdata_we_o (done_we),
    .done_rdata_o    (done_rdata),
    .done_sts_o      (done_sts)
  );
endmodule

// File: tb/tb_cfg_pio_engine.sv
`timescale 1ns/1ps
module tb_cfg_pio_engine;
  import cfg_pio_pkg::*;

  localparam int TMO = 24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;
  logic        req_valid, req_ready, req_write, req_type1;
  logic [63:0] req_addr;
  logic [31:0] req_data;
  logic [3:0]  req_strb;
  logic        cpl_valid_c = 1'b0, man_cpl = 1'b0;
  logic [31:0] cmp_rdata = '0;
  logic [2:0]  cmp_sts = '0;
  int          cmp_mode = 0;   // 0 answer, 1 never ready, 2 accept but silent
  int          cmp_lat = 0;
  int          req_count = 0;
  logic [63:0] seen_addr = '0;
  logic [31:0] seen_data = '0;
  logic [3:0]  seen_strb = '0;
  logic        seen_write = 1'b0, seen_type1 = 1'b0;
  int          checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  cfg_pio_engine #(.ADDR_W(8), .TIMEOUT_CYCLES(TMO)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .irq_o(irq),
    .req_valid_o(req_valid), .req_ready_i(req_ready), .req_write_o(req_write),
    .req_type1_o(req_type1), .req_addr_o(req_addr), .req_data_o(req_data), .req_strb_o(req_strb),
    .cpl_valid_i(cpl_valid_c | man_cpl), .cpl_data_i(cmp_rdata), .cpl_status_i(cmp_sts)
  );

  // behavioural completer
  initial begin
    req_ready = 1'b0;
    forever begin
      @(negedge clk);
      cpl_valid_c = 1'b0;
      req_ready   = 1'b0;
      if (rst_n && req_valid && cmp_mode != 1) begin
        req_ready  = 1'b1;
        seen_addr  = req_addr;  seen_data  = req_data;  seen_strb = req_strb;
        seen_write = req_write; seen_type1 = req_type1;
        req_count++;
        @(negedge clk);
        req_ready = 1'b0;
        if (cmp_mode == 0) begin
          repeat (cmp_lat) @(negedge clk);
          cpl_valid_c = 1'b1;
        end
      end
    end
  end

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    #1 reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    reg_addr = a;
    #0.5 v = reg_rdata;
  endtask

  task automatic wait_done();
    logic [31:0] v;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      rd(OFF_START, v);
      if (v[0] == 1'b0) break;
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int i = 0; i < 10; i++) begin
      rd(8'(i * 4), v);
      chk("R1", "register after reset", v, 0);
    end
    chk("R1", "irq after reset", irq, 0);
    chk("R1", "req_valid after reset", req_valid, 0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr(OFF_CTRL, 32'hFFFF_FFFF); rd(OFF_CTRL, v);  chk("R2", "control keeps type and bit 24", v, 32'h0100_000F);
    wr(OFF_STRB, 32'hFFFF_FFFF); rd(OFF_STRB, v);  chk("R2", "strobe 4 bits", v, 32'hF);
    wr(OFF_ADDR_LO, 32'h1357_9BDF); rd(OFF_ADDR_LO, v); chk("R2", "address low", v, 32'h1357_9BDF);
    wr(OFF_ADDR_HI, 32'h2468_ACE0); rd(OFF_ADDR_HI, v); chk("R2", "address high", v, 32'h2468_ACE0);
    wr(OFF_WDATA, 32'h0F0F_A5A5);   rd(OFF_WDATA, v);   chk("R2", "write data", v, 32'h0F0F_A5A5);
    wr(OFF_STAT, 32'hFFFF_FFFF);    rd(OFF_STAT, v);    chk("R2", "status not writable", v, 0);
    wr(OFF_RDATA, 32'hFFFF_FFFF);   rd(OFF_RDATA, v);   chk("R2", "read data not writable", v, 0);
    rd(8'h28, v); chk("R2", "unmapped offset", v, 0);
    chk("R2", "no request from register writes", req_count, 0);
  endtask

  task automatic t_read0();
    logic [31:0] v;
    int c0 = req_count;
    cmp_mode = 0; cmp_lat = 2; cmp_rdata = 32'h1234_5678; cmp_sts = 3'b000;
    wr(OFF_CTRL, 32'h8);
    wr(OFF_ADDR_LO, (32'd1 << 20) | (32'd2 << 15) | (32'd3 << 12) | 32'h10);
    wr(OFF_ADDR_HI, 32'h0);
    wr(OFF_STRB, 32'hF);
    wr(OFF_START, 32'h1);
    rd(OFF_START, v); chk("R3", "launch bit reads 1 while busy", v, 1);
    chk("R3", "req_valid after launch", req_valid, 1);
    wait_done();
    chk("R3", "request address", seen_addr, 64'h0011_3010);
    chk("R3", "request write flag", seen_write, 0);
    chk("R3", "request type1 flag", seen_type1, 0);
    chk("R3", "request strobe", seen_strb, 4'hF);
    rd(OFF_RDATA, v); chk("R4", "read data captured", v, 32'h1234_5678);
    rd(OFF_STAT, v);  chk("R4", "status", v, 0);
    rd(OFF_START, v); chk("R4", "launch bit cleared", v, 0);
    rd(OFF_ISR, v);   chk("R4", "done flag set", v, 1);
    chk("R11", "one handshake per launch", req_count - c0, 1);
  endtask

  task automatic t_read1();
    logic [31:0] v;
    wr(OFF_ISR, 32'h1);
    cmp_mode = 0; cmp_lat = 0; cmp_rdata = 32'hCAFE_F00D; cmp_sts = 3'b010;
    wr(OFF_CTRL, 32'h9); wr(OFF_ADDR_LO, 32'h0500_0004); wr(OFF_START, 32'h1);
    wait_done();
    chk("R3", "type1 read flag", seen_type1, 1);
    rd(OFF_RDATA, v); chk("R4", "type1 read data", v, 32'hCAFE_F00D);
    rd(OFF_STAT, v);  chk("R4", "status bits 9:7", v, 32'h0000_0100);
    rd(OFF_ISR, v);   chk("R4", "done flag set again", v, 1);
  endtask

  task automatic t_writes();
    logic [31:0] v;
    cmp_mode = 0; cmp_lat = 1; cmp_rdata = 32'h7777_7777; cmp_sts = 3'b000;
    wr(OFF_CTRL, 32'hA); wr(OFF_WDATA, 32'hDEAD_BEEF); wr(OFF_STRB, 32'h3); wr(OFF_START, 32'h1);
    wait_done();
    chk("R3", "write flag", seen_write, 1);
    chk("R3", "write data on request", seen_data, 32'hDEAD_BEEF);
    chk("R3", "write strobe", seen_strb, 4'h3);
    rd(OFF_RDATA, v); chk("R5", "read data kept after write", v, 32'hCAFE_F00D);
    wr(OFF_CTRL, 32'hB); wr(OFF_START, 32'h1);
    wait_done();
    chk("R3", "type1 write flags", {seen_write, seen_type1}, 2'b11);
    rd(OFF_RDATA, v); chk("R5", "read data kept after type1 write", v, 32'hCAFE_F00D);
  endtask

  task automatic t_flag_irq();
    logic [31:0] v;
    wr(OFF_IMASK, 32'h0); #0.5 chk("R7", "irq unmasked", irq, 1);
    wr(OFF_IMASK, 32'h1); #0.5 chk("R7", "irq masked", irq, 0);
    wr(OFF_ISR, 32'h0); rd(OFF_ISR, v); chk("R6", "writing 0 keeps flag", v, 1);
    wr(OFF_ISR, 32'h1); rd(OFF_ISR, v); chk("R6", "writing 1 clears flag", v, 0);
    wr(OFF_IMASK, 32'h0); #0.5 chk("R7", "irq low with flag clear", irq, 0);
  endtask

  task automatic t_busy_lock();
    logic [31:0] v;
    int c0;
    cmp_mode = 2; cmp_rdata = 32'hABCD_0123; cmp_sts = 3'b000;
    wr(OFF_CTRL, 32'h8); wr(OFF_ADDR_LO, 32'h0010_8000); wr(OFF_ADDR_HI, 32'h1);
    wr(OFF_WDATA, 32'h4444); wr(OFF_STRB, 32'hF);
    c0 = req_count;
    wr(OFF_START, 32'h1);
    repeat (2) @(negedge clk);
    wr(OFF_CTRL, 32'hB); wr(OFF_ADDR_LO, 32'h55); wr(OFF_ADDR_HI, 32'h66);
    wr(OFF_WDATA, 32'h77); wr(OFF_STRB, 32'h1); wr(OFF_START, 32'h1);
    rd(OFF_CTRL, v);    chk("R8", "control locked", v, 32'h8);
    rd(OFF_ADDR_LO, v); chk("R8", "address low locked", v, 32'h0010_8000);
    rd(OFF_ADDR_HI, v); chk("R8", "address high locked", v, 32'h1);
    rd(OFF_WDATA, v);   chk("R8", "write data locked", v, 32'h4444);
    rd(OFF_STRB, v);    chk("R8", "strobe locked", v, 32'hF);
    rd(OFF_START, v);   chk("R8", "still busy", v, 1);
    @(negedge clk); man_cpl = 1'b1;
    @(negedge clk); man_cpl = 1'b0;
    rd(OFF_RDATA, v); chk("R8", "completion after locked writes", v, 32'hABCD_0123);
    repeat (3) @(negedge clk);
    chk("R11", "launch while busy issued nothing", req_count - c0, 1);
  endtask

  task automatic t_timeout();
    logic [31:0] v;
    int c0 = req_count;
    wr(OFF_ISR, 32'h1);
    cmp_mode = 1;
    wr(OFF_CTRL, 32'h8); wr(OFF_START, 32'h1);
    repeat (TMO - 1) @(posedge clk);
    #1 rd(OFF_START, v); chk("R9", "busy one cycle before limit", v, 1);
    chk("R9", "request still offered", req_valid, 1);
    @(posedge clk);
    #1 rd(OFF_START, v); chk("R9", "launch bit cleared at limit", v, 0);
    chk("R9", "request withdrawn", req_valid, 0);
    rd(OFF_RDATA, v); chk("R9", "read data all ones", v, 32'hFFFF_FFFF);
    rd(OFF_STAT, v);  chk("R9", "timeout status", v, 32'h0000_0380);
    rd(OFF_ISR, v);   chk("R9", "done flag on timeout", v, 1);
    chk("R9", "no handshake", req_count - c0, 0);
    // accepted but never answered
    cmp_mode = 0; cmp_lat = 0; cmp_rdata = 32'h0BAD_0BAD; cmp_sts = 3'b000;
    wr(OFF_START, 32'h1); wait_done();
    rd(OFF_RDATA, v); chk("R9", "fresh read data", v, 32'h0BAD_0BAD);
    cmp_mode = 2;
    wr(OFF_CTRL, 32'hA); wr(OFF_START, 32'h1); wait_done();
    rd(OFF_RDATA, v); chk("R9", "silent completer read data", v, 32'hFFFF_FFFF);
    rd(OFF_STAT, v);  chk("R9", "silent completer status", v, 32'h0000_0380);
  endtask

  task automatic t_bad_type();
    logic [31:0] v;
    int c0;
    cmp_mode = 0; cmp_lat = 0; cmp_rdata = 32'h1111_2222; cmp_sts = 3'b000;
    wr(OFF_CTRL, 32'h8); wr(OFF_START, 32'h1); wait_done();
    wr(OFF_ISR, 32'h1);
    c0 = req_count;
    wr(OFF_CTRL, 32'h3); wr(OFF_START, 32'h1);
    chk("R10", "no request for bad type", req_valid, 0);
    @(posedge clk); #1;
    rd(OFF_START, v); chk("R10", "ends one cycle after launch", v, 0);
    rd(OFF_RDATA, v); chk("R10", "read data all ones", v, 32'hFFFF_FFFF);
    rd(OFF_STAT, v);  chk("R10", "bad type status", v, 32'h0000_0080);
    rd(OFF_ISR, v);   chk("R10", "done flag set", v, 1);
    repeat (3) @(negedge clk);
    chk("R10", "no handshake", req_count - c0, 0);
  endtask

  task automatic t_clear_race();
    logic [31:0] v;
    cmp_mode = 2; cmp_rdata = 32'h5A5A_5A5A; cmp_sts = 3'b000;
    wr(OFF_ISR, 32'h1);
    rd(OFF_ISR, v); chk("R6", "flag clear before race", v, 0);
    wr(OFF_CTRL, 32'h8); wr(OFF_START, 32'h1);
    repeat (3) @(negedge clk);
    @(negedge clk);
    man_cpl = 1'b1; reg_wr = 1'b1; reg_addr = OFF_ISR; reg_wdata = 32'h1;
    @(posedge clk); #1 reg_wr = 1'b0;
    @(negedge clk); man_cpl = 1'b0;
    rd(OFF_ISR, v);   chk("R6", "completion beats same-cycle clear", v, 1);
    rd(OFF_RDATA, v); chk("R6", "race completion data", v, 32'h5A5A_5A5A);
  endtask

  task automatic t_stray_cpl();
    logic [31:0] v;
    wr(OFF_ISR, 32'h1);
    cmp_rdata = 32'h9999_9999;
    @(negedge clk); man_cpl = 1'b1;
    @(negedge clk); man_cpl = 1'b0;
    rd(OFF_RDATA, v); chk("R11", "stray completion ignored", v, 32'h5A5A_5A5A);
    rd(OFF_ISR, v);   chk("R11", "stray completion sets no flag", v, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    fork
      begin
        t_reset();
        t_regs();
        t_read0();
        t_read1();
        t_writes();
        t_flag_irq();
        t_busy_lock();
        t_timeout();
        t_bad_type();
        t_clear_race();
        t_stray_cpl();
      end
      begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog all requirements actual=hung expected=finished");
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule